// File: doc/BRIEF.md
# Status-Flag Adder/Subtractor

This block is a parameterised integer add/subtract unit that produces a result word and six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It handles plain add, add with incoming carry, plain subtract, subtract with incoming borrow, compare and bitwise test. Compare returns its first operand and sets the flags as subtract does. Test sets the flags from the AND of the two operands. The caller presents an operation code, two operands and the current carry flag under a valid strobe. With the default output register, the result, the flags and a valid strobe appear one cycle later.

The auxiliary-carry and overflow flags are not tapped from an adder's internal carries. A per-bit carry chain is rebuilt from the two operands and the raw result. For additions a bit's carry-out is (a&b) | (~r&(a|b)). For subtractions a bit's borrow-out is (~a&b) | (r&(~a|b)). Both flags are then read off that chain.

Top module: `flagged_addsub`

## Requirements
- R1: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 compare and 5 test. The flag vector is {OF, SF, ZF, AF, PF, CF}, with bit 5 down to bit 0. With OUT_REG=1, `valid_out` is `valid_in` delayed by one cycle. Result and flags are captured only on a valid cycle and hold otherwise. All outputs are zero during and after reset until the first valid cycle.
- R2: Add returns (a+b) mod 2^W, and CF is bit W of the widened sum.
- R3: Add-with-carry adds one more when `cf_in` is 1, and CF is bit W of the widened sum.
- R4: Subtract returns (a-b) mod 2^W, and CF is 1 exactly when a unsigned borrow occurs, which is the top bit of the borrow chain.
- R5: Subtract-with-borrow subtracts one more when `cf_in` is 1, and CF reports the borrow out of the whole operation.
- R6: For add and subtract operations, OF is chain bit W-1 XOR chain bit W-2. This is 1 exactly when the signed result is out of range.
- R7: For add and subtract operations, AF is bit 3 of the carry or borrow chain, for every width.
- R8: PF is 1 when result bits 7..0 hold an even number of ones, whatever the width.
- R9: ZF is 1 only when all W bits of the computed value are zero, and SF is bit W-1 of that value.
- R10: Compare sets every flag exactly as subtract does, and its result output equals operand a.
- R11: Test returns a&b, forces CF, OF and AF to 0, and sets SF, ZF and PF from the AND value.
- R12: `cf_in` has no effect on add, subtract, compare or test.
- R13: The unused codes 6 and 7 behave as add, and `cf_in` is ignored for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Operation request strobe |
| op_in | input | 3 | Operation code |
| a_in | input | WIDTH | First operand (minuend) |
| b_in | input | WIDTH | Second operand (subtrahend) |
| cf_in | input | 1 | Current carry flag |
| valid_out | output | 1 | Result-valid strobe |
| result_out | output | WIDTH | Result word |
| flags_out | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
The bench compares every operation against a signed and unsigned integer model that shares no formula with the chain logic, at 16 bits.

It targets these corner cases:
- Sums and differences that wrap to zero, where a wrong ZF or CF would show.
- Results whose upper byte is nonzero while the low byte is zero, where a design that took parity or zero from the wrong bits would misreport.
- Carries out of bit 3, where a shifted AF tap would miss.
- Signed boundaries 0x7FFF and 0x8000, where an OF taken from the wrong chain bits would flip.
- A set `cf_in` under operations that must ignore it, where a leaked carry would add one.
- Compare, which must return its first operand rather than the difference.
- Idle cycles, which must leave the outputs untouched.

// File: rtl/flagged_addsub_pkg.sv
package flagged_addsub_pkg;
    localparam logic [2:0] OPC_ADD  = 3'd0;
    localparam logic [2:0] OPC_ADDC = 3'd1;
    localparam logic [2:0] OPC_SUB  = 3'd2;
    localparam logic [2:0] OPC_SUBB = 3'd3;
    localparam logic [2:0] OPC_CMP  = 3'd4;
    localparam logic [2:0] OPC_TST  = 3'd5;

    localparam int FLAG_W = 6;
    localparam int FB_CF  = 0;
    localparam int FB_PF  = 1;
    localparam int FB_AF  = 2;
    localparam int FB_ZF  = 3;
    localparam int FB_SF  = 4;
    localparam int FB_OF  = 5;

    function automatic logic even_ones8(input logic [7:0] v);
        return ~(^v);
    endfunction
endpackage

// File: rtl/fas_core.sv
module fas_core
    import flagged_addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cf_in,
    output logic [WIDTH-1:0] raw,
    output logic             add_cout,
    output logic             is_sub,
    output logic             is_tst,
    output logic             is_cmp
);
    localparam int EXT_W = WIDTH + 1;

    logic             cin_eff;
    logic [EXT_W-1:0] add_ext;
    logic [EXT_W-1:0] sub_ext;

    always_comb begin
        is_sub  = (op == OPC_SUB) || (op == OPC_SUBB) || (op == OPC_CMP);
        is_tst  = (op == OPC_TST);
        is_cmp  = (op == OPC_CMP);
        cin_eff = cf_in && ((op == OPC_ADDC) || (op == OPC_SUBB));
        add_ext = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin_eff};
        sub_ext = {1'b0, a} - {1'b0, b} - {{WIDTH{1'b0}}, cin_eff};
        add_cout = add_ext[WIDTH];
        if (is_tst)      raw = a & b;
        else if (is_sub) raw = sub_ext[WIDTH-1:0];
        else             raw = add_ext[WIDTH-1:0];
    end
endmodule

// File: rtl/fas_chain.sv
module fas_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] r,
    input  logic             is_sub,
    output logic             aux,
    output logic             ovf,
    output logic             borrow
);
    logic [WIDTH-1:0] chain;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic carry_bit;
        logic borrow_bit;
        assign carry_bit  = (a[i] & b[i]) | (~r[i] & (a[i] | b[i]));
        assign borrow_bit = (~a[i] & b[i]) | (r[i] & (~a[i] | b[i]));
        assign chain[i]   = is_sub ? borrow_bit : carry_bit;
    end

    assign aux    = chain[3];
    assign ovf    = chain[WIDTH-1] ^ chain[WIDTH-2];
    assign borrow = chain[WIDTH-1];
endmodule

// File: rtl/fas_flags.sv
module fas_flags
    import flagged_addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]  raw,
    input  logic              is_sub,
    input  logic              is_tst,
    input  logic              add_cout,
    input  logic              aux,
    input  logic              ovf,
    input  logic              borrow,
    output logic [FLAG_W-1:0] flags
);
    always_comb begin
        flags        = '0;
        flags[FB_CF] = is_tst ? 1'b0 : (is_sub ? borrow : add_cout);
        flags[FB_OF] = is_tst ? 1'b0 : ovf;
        flags[FB_AF] = is_tst ? 1'b0 : aux;
        flags[FB_ZF] = (raw == '0);
        flags[FB_SF] = raw[WIDTH-1];
        flags[FB_PF] = even_ones8(raw[7:0]);
    end
endmodule

// File: rtl/flagged_addsub.sv
module flagged_addsub
    import flagged_addsub_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [2:0]        op_in,
    input  logic [WIDTH-1:0]  a_in,
    input  logic [WIDTH-1:0]  b_in,
    input  logic              cf_in,
    output logic              valid_out,
    output logic [WIDTH-1:0]  result_out,
    output logic [FLAG_W-1:0] flags_out
);
    typedef struct packed {
        logic              vld;
        logic [WIDTH-1:0]  res;
        logic [FLAG_W-1:0] flg;
    } out_t;

    logic [WIDTH-1:0]  raw;
    logic              add_cout, is_sub, is_tst, is_cmp;
    logic              aux, ovf, borrow;
    logic [FLAG_W-1:0] flg_c;
    logic [WIDTH-1:0]  res_c;

    fas_core #(.WIDTH(WIDTH)) core_i (
        .op(op_in), .a(a_in), .b(b_in), .cf_in(cf_in),
        .raw(raw), .add_cout(add_cout),
        .is_sub(is_sub), .is_tst(is_tst), .is_cmp(is_cmp)
    );

    fas_chain #(.WIDTH(WIDTH)) chain_i (
        .a(a_in), .b(b_in), .r(raw), .is_sub(is_sub),
        .aux(aux), .ovf(ovf), .borrow(borrow)
    );

    fas_flags #(.WIDTH(WIDTH)) flags_i (
        .raw(raw), .is_sub(is_sub), .is_tst(is_tst), .add_cout(add_cout),
        .aux(aux), .ovf(ovf), .borrow(borrow), .flags(flg_c)
    );

    assign res_c = is_cmp ? a_in : raw;

    if (OUT_REG) begin : g_reg
        out_t st_d, st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = valid_in;
            if (valid_in) begin
                st_d.res = res_c;
                st_d.flg = flg_c;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end

        assign valid_out  = st_q.vld;
        assign result_out = st_q.res;
        assign flags_out  = st_q.flg;

        assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
            valid_in |=> valid_out);
        assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_in |=> (!valid_out && $stable(result_out) && $stable(flags_out)));
        assert_cmp_returns_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && op_in == OPC_CMP) |=> (result_out == $past(a_in)));
        assert_test_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && op_in == OPC_TST) |=>
                (!flags_out[FB_CF] && !flags_out[FB_OF] && !flags_out[FB_AF]));
        assert_zero_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && op_in != OPC_CMP) |=>
                ((flags_out[FB_ZF] == (result_out == '0)) && (flags_out[FB_SF] == result_out[WIDTH-1])));
        assert_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && op_in != OPC_CMP) |=> (flags_out[FB_PF] == ~(^result_out[7:0])));
    end else begin : g_comb
        assign valid_out  = valid_in;
        assign result_out = res_c;
        assign flags_out  = flg_c;
    end
endmodule

// File: tb/flagged_addsub_tb.sv
`timescale 1ns/1ps
module flagged_addsub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [2:0]  op_in = '0;
    logic [15:0] a_in = '0;
    logic [15:0] b_in = '0;
    logic        cf_in = 1'b0;
    logic        valid_out;
    logic [15:0] result_out;
    logic [5:0]  flags_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    flagged_addsub #(.WIDTH(16), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_in(op_in),
        .a_in(a_in), .b_in(b_in), .cf_in(cf_in),
        .valid_out(valid_out), .result_out(result_out), .flags_out(flags_out)
    );

    // stimulus: {op, cf, a, b}
    localparam logic [35:0] VEC [19] = '{
        {3'd0, 1'b0, 16'h1234, 16'h4321},
        {3'd0, 1'b0, 16'hFFFF, 16'h0001},
        {3'd0, 1'b0, 16'h7FFF, 16'h0001},
        {3'd0, 1'b0, 16'h8000, 16'h8000},
        {3'd1, 1'b1, 16'hFFFF, 16'h0000},
        {3'd1, 1'b1, 16'h7FFE, 16'h0001},
        {3'd1, 1'b0, 16'h0008, 16'h0008},
        {3'd2, 1'b0, 16'h0000, 16'h0001},
        {3'd2, 1'b0, 16'h8000, 16'h0001},
        {3'd2, 1'b0, 16'h1234, 16'h1234},
        {3'd3, 1'b1, 16'h0005, 16'h0005},
        {3'd3, 1'b1, 16'h0000, 16'hFFFF},
        {3'd3, 1'b0, 16'h0010, 16'h0001},
        {3'd4, 1'b0, 16'h0003, 16'h0005},
        {3'd4, 1'b1, 16'h8000, 16'h7FFF},
        {3'd5, 1'b1, 16'hF0F0, 16'hFF00},
        {3'd5, 1'b0, 16'h00FF, 16'hFF00},
        {3'd6, 1'b1, 16'h1000, 16'h2000},
        {3'd7, 1'b1, 16'hFFFF, 16'hFFFF}
    };

    // independent integer model: returns {result, OF, SF, ZF, AF, PF, CF}
    function automatic logic [21:0] model(input logic [2:0] op, input logic cf,
                                          input logic [15:0] a, input logic [15:0] b);
        int ua = int'(a);
        int ub = int'(b);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int c  = ((op == 3'd1 || op == 3'd3) && cf) ? 1 : 0;
        int full;
        int sv;
        logic [15:0] r;
        logic fc, fo, fa;
        if (op == 3'd5) begin
            r = a & b; fc = 0; fo = 0; fa = 0;
        end else if (op == 3'd2 || op == 3'd3 || op == 3'd4) begin
            full = ua - ub - c; sv = sa - sb - c;
            r = full[15:0]; fc = (full < 0);
            fo = (sv > 32767) || (sv < -32768); fa = a[4] ^ b[4] ^ r[4];
        end else begin
            full = ua + ub + c; sv = sa + sb + c;
            r = full[15:0]; fc = (full > 65535);
            fo = (sv > 32767) || (sv < -32768); fa = a[4] ^ b[4] ^ r[4];
        end
        return {(op == 3'd4) ? a : r, fo, r[15], (r == 16'h0), fa, ~(^r[7:0]), fc};
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2 R6 R7 R8 R9";
            3'd1: return "R3 R6 R7 R8 R9";
            3'd2: return "R4 R6 R7 R8 R9";
            3'd3: return "R5 R6 R7 R8 R9";
            3'd4: return "R10";
            3'd5: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic v, input logic [15:0] er, input logic [5:0] ef);
        n_checks++;
        if (valid_out !== v || result_out !== er || flags_out !== ef) begin
            n_fail++;
            $display("FAIL %s: got vld=%b res=%h flg=%b, expected vld=%b res=%h flg=%b",
                     tag, valid_out, result_out, flags_out, v, er, ef);
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic cf, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        valid_in = 1'b1; op_in = op; cf_in = cf; a_in = a; b_in = b;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        logic [21:0] exp_v;
        logic [15:0] held_r;
        logic [5:0]  held_f;
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 16'h0, 6'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 16'h0, 6'h0);

        for (int i = 0; i < 19; i++) begin
            run_op(VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
            exp_v = model(VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
            check(op_tag(VEC[i][35:33]), 1'b1, exp_v[21:6], exp_v[5:0]);
        end

        // directed corner cases with hand-worked values
        run_op(3'd0, 1'b0, 16'h0100, 16'h0000);
        check("R8 parity low byte only", 1'b1, 16'h0100, 6'b000010);
        run_op(3'd0, 1'b0, 16'h000F, 16'h0001);
        check("R7 carry out of bit 3", 1'b1, 16'h0010, 6'b000100);
        run_op(3'd0, 1'b0, 16'h7FFF, 16'h0001);
        check("R6 signed overflow", 1'b1, 16'h8000, 6'b110110);
        run_op(3'd2, 1'b0, 16'h0000, 16'h0001);
        check("R4 borrow", 1'b1, 16'hFFFF, 6'b010111);
        run_op(3'd0, 1'b1, 16'h0001, 16'h0001);
        check("R12 add ignores cf_in", 1'b1, 16'h0002, 6'b000000);
        run_op(3'd2, 1'b1, 16'h0005, 16'h0003);
        check("R12 sub ignores cf_in", 1'b1, 16'h0002, 6'b000000);
        run_op(3'd4, 1'b0, 16'h0002, 16'h0003);
        check("R10 compare", 1'b1, 16'h0002, 6'b010111);
        run_op(3'd5, 1'b1, 16'hFFFF, 16'h8001);
        check("R11 test", 1'b1, 16'h8001, 6'b010000);
        run_op(3'd3, 1'b1, 16'h0001, 16'h0000);
        check("R5 R9 borrow-in to zero", 1'b1, 16'h0000, 6'b001010);

        // idle cycles must hold result and flags
        run_op(3'd0, 1'b0, 16'h1111, 16'h2222);
        held_r = 16'h3333; held_f = 6'b000010;
        check("R2 before idle", 1'b1, held_r, held_f);
        @(negedge clk);
        op_in = 3'd2; a_in = 16'h0000; b_in = 16'hFFFF; cf_in = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle hold", 1'b0, held_r, held_f);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule